// File: doc/BRIEF.md
# Video Stream Stable Qualifier

The block decides when an incoming video stream can be trusted. A start pulse arms it. If the PLL-lock input is low at that moment, it reports a lock error on the next cycle and waits for nothing. Otherwise it waits a settling interval and then polls a hot-plug status at a fixed interval. The number of hot-plug polls is bounded.

Once the hot-plug status reads present, the block samples a stream-present status on a slower periodic tick. It declares the stream established only when the run of consecutive present samples grows beyond a set length. Any absent sample drops the run back to zero. Every stream sample uses up one unit of a fixed budget, and when the budget is spent without qualification the block reports a timeout.

The result is held on the done, ok, timeout and lock-error outputs until the next accepted start. A sequencer polls these outputs before it enables downstream video logic.

Top module: `stream_qual`

## Requirements
- R1: While rst_ni is low, and after release until a start is accepted, done_o, ok_o, timeout_o and lock_err_o are all 0.
- R2: A start accepted while pll_lock_i is 0 sets done_o and lock_err_o on the next clock edge, with ok_o and timeout_o at 0.
- R3: After a start accepted with pll_lock_i at 1, hpd_i is first sampled HPD_SETTLE_CYC clock edges after the start edge, then every HPD_POLL_CYC edges. The first sample that reads 1 ends the hot-plug wait.
- R4: If HPD_BUDGET hot-plug samples all read 0, done_o and timeout_o are set at the edge of the last sample.
- R5: After the hot-plug wait ends, stream_on_i is sampled every SAMPLE_CYC edges. done_o and ok_o are set at the edge of the sample that brings the run of consecutive 1 samples to RUN_LEN+1 (11 by default).
- R6: A stream sample reading 0 resets the consecutive run to zero, so the count starts again from the next sample.
- R7: If STREAM_BUDGET stream samples pass without qualification, done_o and timeout_o are set at the edge of the last sample.
- R8: When qualification lands on the final budgeted stream sample, the result is ok, not timeout.
- R9: done_o is set with exactly one of ok_o, timeout_o or lock_err_o. All four outputs hold their values until the next accepted start, which clears them.
- R10: start_i is ignored while a wait is in progress, and the outcome and its timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms the block when it is idle |
| pll_lock_i | input | 1 | PLL lock status, checked when a start is accepted |
| hpd_i | input | 1 | Hot-plug present status |
| stream_on_i | input | 1 | Video stream present status |
| done_o | output | 1 | The wait has ended; a result is held |
| ok_o | output | 1 | The stream qualified |
| timeout_o | output | 1 | The hot-plug or stream budget ran out |
| lock_err_o | output | 1 | The start was refused because the PLL was unlocked |

## Verification
Two events can fall on the same stream sample: the run reaching its qualifying length and the stream budget running out. The bench provokes this with one pattern whose only absent sample leaves exactly eleven present samples ending on the last budgeted sample, and expects ok. A second pattern moves that absent sample one place later, leaving ten present samples, and expects timeout at the same edge. In both cases done_o is checked low just before that edge and set just after it.

// File: rtl/stream_qual_pkg.sv
package stream_qual_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_HPD, SQ_STRM} sq_state_e;
  typedef enum logic [1:0] {RES_NONE, RES_OK, RES_TMO, RES_LOCK} sq_res_e;
endpackage

// File: rtl/sq_timer.sv
module sq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_val_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_o) cnt_q <= reload_val_i;
    else if (en_i)   cnt_q <= cnt_q - W'(1);
  end
endmodule

// File: rtl/sq_budget.sv
module sq_budget #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // high while the sample now being taken is the final one allowed
  assign last_o = (cnt_q == LAST_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (inc_i && !last_o)     cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/sq_run.sv
module sq_run #(
  parameter int unsigned RUN_LEN = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic smp_i,
  input  logic hit_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q;

  // run exceeds RUN_LEN on this hit
  assign fire_o = smp_i && hit_i && (cnt_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (smp_i) begin
      if (!hit_i)              cnt_q <= '0;
      else if (cnt_q != FULL)  cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/stream_qual.sv
module stream_qual
  import stream_qual_pkg::*;
#(
  parameter int unsigned SAMPLE_CYC     = 125000,
  parameter int unsigned HPD_SETTLE_CYC = 25000,
  parameter int unsigned HPD_POLL_CYC   = 1250,
  parameter int unsigned HPD_BUDGET     = 100,
  parameter int unsigned STREAM_BUDGET  = 100,
  parameter int unsigned RUN_LEN        = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pll_lock_i,
  input  logic hpd_i,
  input  logic stream_on_i,
  output logic done_o,
  output logic ok_o,
  output logic timeout_o,
  output logic lock_err_o
);
  localparam int unsigned MAX_AB  = (SAMPLE_CYC > HPD_SETTLE_CYC) ? SAMPLE_CYC : HPD_SETTLE_CYC;
  localparam int unsigned MAX_CYC = (MAX_AB > HPD_POLL_CYC) ? MAX_AB : HPD_POLL_CYC;
  localparam int unsigned TW      = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(HPD_SETTLE_CYC - 1);
  localparam logic [TW-1:0] POLL_LD   = TW'(HPD_POLL_CYC - 1);
  localparam logic [TW-1:0] SAMPLE_LD = TW'(SAMPLE_CYC - 1);

  sq_state_e state_q, state_d;
  sq_res_e   res_q, res_d;

  logic busy, accept, tick;
  logic hpd_smp, strm_smp, hpd_last, strm_last, run_fire;
  logic tmr_load;
  logic [TW-1:0] tmr_load_val, tmr_reload_val;

  assign busy     = (state_q != SQ_IDLE);
  assign accept   = start_i && !busy;
  assign hpd_smp  = tick && (state_q == SQ_HPD);
  assign strm_smp = tick && (state_q == SQ_STRM);

  assign tmr_load       = (accept && pll_lock_i) || (hpd_smp && hpd_i);
  assign tmr_load_val   = accept ? SETTLE_LD : SAMPLE_LD;
  assign tmr_reload_val = (state_q == SQ_HPD) ? POLL_LD : SAMPLE_LD;

  sq_timer #(.W(TW)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (busy),
    .load_i      (tmr_load),
    .load_val_i  (tmr_load_val),
    .reload_val_i(tmr_reload_val),
    .tick_o      (tick)
  );

  sq_budget #(.LIMIT(HPD_BUDGET)) u_hpd_budget (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .inc_i (hpd_smp),
    .last_o(hpd_last)
  );

  sq_budget #(.LIMIT(STREAM_BUDGET)) u_strm_budget (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .inc_i (strm_smp),
    .last_o(strm_last)
  );

  sq_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .smp_i (strm_smp),
    .hit_i (stream_on_i),
    .fire_o(run_fire)
  );

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          if (pll_lock_i) begin
            state_d = SQ_HPD;
            res_d   = RES_NONE;
          end else begin
            res_d   = RES_LOCK;
          end
        end
      end
      SQ_HPD: begin
        if (hpd_smp) begin
          if (hpd_i) state_d = SQ_STRM;
          else if (hpd_last) begin
            state_d = SQ_IDLE;
            res_d   = RES_TMO;
          end
        end
      end
      SQ_STRM: begin
        if (strm_smp) begin
          // qualification takes priority over an exhausted budget
          if (run_fire) begin
            state_d = SQ_IDLE;
            res_d   = RES_OK;
          end else if (strm_last) begin
            state_d = SQ_IDLE;
            res_d   = RES_TMO;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      res_q   <= RES_NONE;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
    end
  end

  assign done_o     = (res_q != RES_NONE);
  assign ok_o       = (res_q == RES_OK);
  assign timeout_o  = (res_q == RES_TMO);
  assign lock_err_o = (res_q == RES_LOCK);
endmodule

// File: rtl/stream_qual_chk.sv
module stream_qual_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic pll_lock_i,
  input logic stream_on_i,
  input logic busy,
  input logic done_o,
  input logic ok_o,
  input logic timeout_o,
  input logic lock_err_o
);
  a_r2_lock_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy && !pll_lock_i) |=> (done_o && lock_err_o && !busy));

  a_r3_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy && pll_lock_i) |=> (busy && !done_o));

  a_r5_ok_needs_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> $past(stream_on_i));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable({done_o, ok_o, timeout_o, lock_err_o}));

  a_r9_quiet_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !done_o);

  a_r10_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> !lock_err_o);
endmodule

bind stream_qual stream_qual_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .pll_lock_i (pll_lock_i),
  .stream_on_i(stream_on_i),
  .busy       (busy),
  .done_o     (done_o),
  .ok_o       (ok_o),
  .timeout_o  (timeout_o),
  .lock_err_o (lock_err_o)
);

// File: tb/stream_qual_test.sv
`timescale 1ns/1ps
module stream_qual_test;
  localparam int unsigned SAMPLE_CYC = 4;
  localparam int unsigned SETTLE     = 5;
  localparam int unsigned POLL       = 3;
  localparam int unsigned HPD_BUD    = 4;
  localparam int unsigned STRM_BUD   = 16;

  typedef struct packed {
    logic [7:0]  miss;  // low hot-plug polls before a high one
    logic [15:0] pat;   // bit k: stream status at stream sample k+1
    logic        exp_ok;
    logic [7:0]  n;     // stream samples until done (0: hot-plug timeout)
    logic        poke;  // pulse start during the wait
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd0, 16'hFFFF, 1'b1, 8'd11, 1'b0},
    '{8'd2, 16'hFFFB, 1'b1, 8'd14, 1'b1},
    '{8'd0, 16'h0000, 1'b0, 8'd16, 1'b0},
    '{8'd3, 16'hFFEF, 1'b1, 8'd16, 1'b0},
    '{8'd0, 16'hFFDF, 1'b0, 8'd16, 1'b0},
    '{8'd4, 16'h0000, 1'b0, 8'd0,  1'b0},
    '{8'd1, 16'hAAAA, 1'b0, 8'd16, 1'b0}
  };

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, pll_lock_i = 1, hpd_i = 0, stream_on_i = 0;
  logic done_o, ok_o, timeout_o, lock_err_o;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  stream_qual #(
    .SAMPLE_CYC(SAMPLE_CYC), .HPD_SETTLE_CYC(SETTLE), .HPD_POLL_CYC(POLL),
    .HPD_BUDGET(HPD_BUD), .STREAM_BUDGET(STRM_BUD), .RUN_LEN(10)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .pll_lock_i(pll_lock_i),
    .hpd_i(hpd_i), .stream_on_i(stream_on_i), .done_o(done_o), .ok_o(ok_o),
    .timeout_o(timeout_o), .lock_err_o(lock_err_o)
  );

  function automatic string vtag(int i);
    case (i)
      0: return "R5";
      1: return "R6/R3/R10";
      2: return "R7";
      3: return "R8";
      4: return "R8/R6";
      5: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit cond, string req, string what, int act, int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int outs();
    return {done_o, ok_o, timeout_o, lock_err_o};
  endfunction

  task automatic run_vec(int i);
    vec_t v = VECS[i];
    int npolls = (v.miss < HPD_BUD) ? v.miss + 1 : HPD_BUD;
    hpd_i = 0; stream_on_i = 0;
    @(negedge clk) start_i = 1;
    @(posedge clk);
    @(negedge clk) start_i = 0;
    for (int j = 0; j < npolls; j++) begin
      if (j > 0) @(negedge clk);
      hpd_i = (j >= v.miss);
      if (v.n == 0 && j == npolls - 1)
        chk(done_o == 0, vtag(i), "done before last poll", done_o, 0);
      repeat (j == 0 ? SETTLE : POLL) @(posedge clk);
    end
    if (v.n != 0) begin
      for (int k = 0; k < v.n; k++) begin
        @(negedge clk);
        stream_on_i = v.pat[k];
        start_i = v.poke && (k == 0);
        if (k == v.n - 1)
          chk(done_o == 0, vtag(i), "done before final sample", done_o, 0);
        repeat (SAMPLE_CYC) @(posedge clk);
      end
    end
    @(negedge clk) start_i = 0;
    chk(outs() == {1'b1, v.exp_ok, !v.exp_ok, 1'b0}, vtag(i), "result {done,ok,tmo,lock}",
        outs(), {1'b1, v.exp_ok, !v.exp_ok, 1'b0});
  endtask

  task automatic finish_up();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 50000);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(outs() == 0, "R1", "outputs in reset", outs(), 0);
    rst_ni = 1;
    repeat (5) @(negedge clk);
    chk(outs() == 0, "R1", "outputs after release", outs(), 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R9: result held while inputs move and no start arrives
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      hpd_i = c[0]; stream_on_i = c[1];
    end
    chk(outs() == 4'b1010, "R9", "held result", outs(), 4'b1010);

    // R2: unlocked start refused at once
    pll_lock_i = 0;
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    chk(outs() == 4'b1001, "R2", "lock refuse", outs(), 4'b1001);
    repeat (10) @(negedge clk);
    chk(outs() == 4'b1001, "R2", "lock error held", outs(), 4'b1001);

    // R9: accepted start clears the held result
    pll_lock_i = 1; hpd_i = 0;
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    chk(outs() == 0, "R9", "cleared by start", outs(), 0);
    repeat (SETTLE + POLL * HPD_BUD + 4) @(negedge clk);
    chk(outs() == 4'b1010, "R4", "hot-plug timeout", outs(), 4'b1010);

    finish_up();
  end
endmodule